// File: doc/BRIEF.md
# Galois Pseudo-Random Sequence Generator

This block is a five-stage linear feedback shift register built in the one-to-many form: the most significant stage is fed back and XORed into the inputs of several lower stages at once, so each step costs only one gate level. With the chosen feedback points the register walks through every nonzero 5-bit value, 31 of them, before it comes back to where it started. It is used as a cheap source of pseudo-random bits or words, for example to scramble data or to drive test patterns.

A design around it resets the register or loads a seed, then raises the step enable whenever it needs a new value. It reads either the whole register or the single serial bit from the top stage. All-zero is the one state the register can never leave. A zero seed is therefore never loaded: the block puts a fixed nonzero value in its place and raises a lock-up flag, which is also raised if the register ever holds all zeros.

Top module: `galois_prng`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 5'b00001 after that edge and `lockup` becomes 0. Reset is synchronous, so nothing changes between edges.
- R2: Bit 0 of `state` is stage 1 and bit 4 is stage 5. On an edge with `step_en` high and no load or reset, stage 1 takes the old stage 5. Stages 2, 3 and 4 each take the old previous stage XOR the old stage 5. Stage 5 takes the old stage 4 with no XOR.
- R3: `serial_out` always equals bit 4 of `state`, the stage at the most significant end.
- R4: On an edge with `rst`, `load` and `step_en` all low, `state` keeps its value.
- R5: On an edge with `load` high, `rst` low and a nonzero `seed`, `state` equals `seed` after that edge, whatever `step_en` is. A load wins over a step.
- R6: On an edge with `load` high, `rst` low and `seed` equal to 5'b00000, `state` becomes 5'b00001 and `lockup` is 1 for that one cycle only.
- R7: From any nonzero value, exactly 31 enabled steps bring `state` back to that value. None of the 30 values in between repeats a value or equals the start.
- R8: `lockup` is high after an edge only if that edge loaded an all-zero seed, or if the register holds 5'b00000.
- R9: `state` is never 5'b00000 after any edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Seed-load strobe, takes priority over stepping |
| seed | input | 5 | Value to load, bit 0 is stage 1 |
| step_en | input | 1 | Advance the register by one step |
| state | output | 5 | Registered register contents, bit 0 is stage 1 |
| serial_out | output | 1 | Most significant stage |
| lockup | output | 1 | Registered all-zero / zero-seed flag |

## Verification
The all-zero state cannot be reached by stepping, so the lock-up path is hard to exercise. The only way to reach it from the ports is to present a zero seed. The stimulus does this directly, back to back and together with a raised enable, and it also slips zero seeds into the random traffic. The bench then checks that the flag falls on the next ordinary cycle. Full-period walks start from every one of the 31 nonzero seeds, which shows that the cycle is maximal no matter where it begins.

// File: rtl/galois_prng_pkg.sv
package galois_prng_pkg;

  localparam int          PRNG_STAGES  = 5;
  // bit i set: stage i+1 receives the feedback XOR at its input
  localparam logic [4:0]  PRNG_TAPS    = 5'b01110;
  localparam logic [4:0]  PRNG_DEFAULT = 5'b00001;

  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_STEP   = 3'd1,
    ACT_LOAD   = 3'd2,
    ACT_RESEED = 3'd3,
    ACT_RESET  = 3'd4
  } prng_act_e;

endpackage

// File: rtl/galois_prng_step.sv
module galois_prng_step #(
  parameter int                 STAGES = 5,
  parameter logic [STAGES-1:0]  TAPS   = 5'b01110
) (
  input  logic [STAGES-1:0] cur,
  output logic [STAGES-1:0] nxt
);

  localparam int TOP = STAGES - 1;

  logic fb;
  assign fb = cur[TOP];

  // stage 1 wraps the top bit around
  assign nxt[0] = fb;

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    if (TAPS[k]) begin : g_tap
      assign nxt[k] = cur[k-1] ^ fb;
    end else begin : g_plain
      assign nxt[k] = cur[k-1];
    end
  end

endmodule

// File: rtl/galois_prng_seed.sv
module galois_prng_seed #(
  parameter int                STAGES  = 5,
  parameter logic [STAGES-1:0] DEFAULT = 5'b00001
) (
  input  logic [STAGES-1:0] seed_in,
  output logic [STAGES-1:0] seed_ok,
  output logic              seed_zero
);

  assign seed_zero = ~|seed_in;
  assign seed_ok   = seed_zero ? DEFAULT : seed_in;

endmodule

// File: rtl/galois_prng_ctrl.sv
module galois_prng_ctrl
  import galois_prng_pkg::*;
(
  input  logic      rst,
  input  logic      load,
  input  logic      step_en,
  input  logic      seed_zero,
  output prng_act_e act
);

  always_comb begin
    if (rst)                act = ACT_RESET;
    else if (load)          act = seed_zero ? ACT_RESEED : ACT_LOAD;
    else if (step_en)       act = ACT_STEP;
    else                    act = ACT_HOLD;
  end

endmodule

// File: rtl/galois_prng.sv
module galois_prng
  import galois_prng_pkg::*;
#(
  parameter int                STAGES  = PRNG_STAGES,
  parameter logic [STAGES-1:0] TAPS    = PRNG_TAPS,
  parameter logic [STAGES-1:0] DEFAULT = PRNG_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STAGES-1:0] seed,
  input  logic              step_en,
  output logic [STAGES-1:0] state,
  output logic              serial_out,
  output logic              lockup
);

  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] state_q, state_d, stepped, seed_ok;
  logic              seed_zero, lock_q, lock_d;
  prng_act_e         act;

  galois_prng_step #(.STAGES(STAGES), .TAPS(TAPS)) u_step (
    .cur (state_q),
    .nxt (stepped)
  );

  galois_prng_seed #(.STAGES(STAGES), .DEFAULT(DEFAULT)) u_seed (
    .seed_in   (seed),
    .seed_ok   (seed_ok),
    .seed_zero (seed_zero)
  );

  galois_prng_ctrl u_ctrl (
    .rst       (rst),
    .load      (load),
    .step_en   (step_en),
    .seed_zero (seed_zero),
    .act       (act)
  );

  always_comb begin
    unique case (act)
      ACT_RESET:  state_d = DEFAULT;
      ACT_RESEED: state_d = DEFAULT;
      ACT_LOAD:   state_d = seed_ok;
      ACT_STEP:   state_d = stepped;
      default:    state_d = state_q;
    endcase
  end

  assign lock_d = (act != ACT_RESET) &&
                  ((act == ACT_RESEED) || (state_d == '0));

  always_ff @(posedge clk) begin
    state_q <= state_d;
    lock_q  <= lock_d;
  end

  assign state      = state_q;
  assign serial_out = state_q[MSB];
  assign lockup     = lock_q;

endmodule

// File: rtl/galois_prng_chk.sv
module galois_prng_chk #(
  parameter int STAGES = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [STAGES-1:0] seed,
  input logic              step_en,
  input logic [STAGES-1:0] state,
  input logic              serial_out,
  input logic              lockup
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1
  reset_value_chk: assert property (@(posedge clk)
    (past_ok && $past(rst)) |-> (state == 1 && !lockup));

  // R3
  serial_tap_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (serial_out == state[STAGES-1]));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!rst && !load && !step_en)) |-> $stable(state));

  // R5
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!rst && load && seed != 0)) |-> (state == $past(seed)));

  // R6
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!rst && load && seed == 0)) |-> (state == 1 && lockup));

  // R8
  lock_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && lockup) |-> ($past(load && seed == 0) || state == 0));

  // R9
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (state != 0));

endmodule

bind galois_prng galois_prng_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .seed       (seed),
  .step_en    (step_en),
  .state      (state),
  .serial_out (serial_out),
  .lockup     (lockup)
);

// File: tb/tb_galois_prng.sv
`timescale 1ns/1ps
module tb_galois_prng;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [4:0] seed = '0;
  logic       step_en = 1'b0;
  logic [4:0] state;
  logic       serial_out, lockup;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_state;
  logic       exp_lock;

  always #2.5 clk = ~clk;

  galois_prng dut (
    .clk(clk), .rst(rst), .load(load), .seed(seed), .step_en(step_en),
    .state(state), .serial_out(serial_out), .lockup(lockup)
  );

  // R2 rule written from the stage description
  function automatic logic [4:0] step_of(input logic [4:0] s);
    logic [4:0] n;
    n[0] = s[4];
    n[1] = s[0] ^ s[4];
    n[2] = s[1] ^ s[4];
    n[3] = s[2] ^ s[4];
    n[4] = s[3];
    return n;
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  // drive at negedge, let one edge pass, sample 1 ns after it
  task automatic cycle(input logic r, input logic l, input logic [4:0] sd, input logic e);
    @(negedge clk);
    rst = r; load = l; seed = sd; step_en = e;
    if (r) begin exp_state = 5'b00001; exp_lock = 1'b0; end
    else if (l && sd == 0) begin exp_state = 5'b00001; exp_lock = 1'b1; end
    else if (l) begin exp_state = sd; exp_lock = 1'b0; end
    else if (e) begin exp_state = step_of(exp_state); exp_lock = 1'b0; end
    else exp_lock = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string req);
    check(req, state, exp_state);
    check({req, " lockup"}, {4'b0, lockup}, {4'b0, exp_lock});
    check("R3 serial", {4'b0, serial_out}, {4'b0, state[4]});
    check("R9 nonzero", {4'b0, state == 0}, 5'b0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_state = 5'b00001; exp_lock = 1'b0;
    cycle(1, 0, 0, 0);
    check_all("R1 reset");

    // directed: reset while load and enable present
    cycle(0, 1, 5'b10101, 0);
    check_all("R5 load");
    cycle(1, 1, 5'b11111, 1);
    check_all("R1 reset priority");

    // R2 directed steps from a seed with top bit set
    cycle(0, 1, 5'b10000, 0);
    cycle(0, 0, 0, 1);
    check("R2 step", state, 5'b01111);
    cycle(0, 0, 0, 1);
    check_all("R2 step2");

    // R4 hold
    for (int i = 0; i < 4; i++) begin
      cycle(0, 0, 5'b11111, 0);
      check_all("R4 hold");
    end

    // R5 load wins over step
    cycle(0, 1, 5'b01010, 1);
    check("R5 priority", state, 5'b01010);

    // R6 zero seed, back to back, with enable
    cycle(0, 1, 5'b00000, 1);
    check_all("R6 zero seed");
    check("R6 flag", {4'b0, lockup}, 5'b00001);
    cycle(0, 1, 5'b00000, 0);
    check_all("R6 zero seed again");
    cycle(0, 0, 0, 1);
    check_all("R6 flag drops");
    check("R8 flag low", {4'b0, lockup}, 5'b0);

    // R7 full period from every nonzero seed
    for (int s = 1; s < 32; s++) begin
      logic [31:0] seen;
      logic        dup;
      seen = '0; dup = 1'b0;
      cycle(0, 1, 5'(s), 0);
      seen[s] = 1'b1;
      for (int k = 1; k <= 31; k++) begin
        cycle(0, 0, 0, 1);
        if (k < 31) begin
          if (seen[state]) dup = 1'b1;
          seen[state] = 1'b1;
        end
      end
      check("R7 period return", state, 5'(s));
      check("R7 no repeat", {4'b0, dup}, 5'b0);
      check("R7 all visited", {4'b0, seen == 32'hFFFF_FFFE}, 5'b00001);
    end

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic r, l, e;
      logic [4:0] sd;
      r  = ($urandom % 50) == 0;
      l  = ($urandom % 8) == 0;
      e  = ($urandom % 4) != 0;
      sd = (($urandom % 6) == 0) ? 5'b0 : 5'($urandom);
      cycle(r, l, sd, e);
      check_all("R2 R5 R6 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule